// File: doc/BRIEF.md
# SMBus Port Steering Register Bank

This block sits beside a single SMBus host controller and lets that one controller reach any of four physical bus segments. Software reaches a small bank of power-management bytes through two I/O locations: the first holds an index, the second reads or writes the byte that the index points at. A two-bit port field held in that bank picks which segment's clock and data pair is joined to the controller. The open-drain pull-down enables from the controller go only to the chosen pair. The line levels coming back from that pair return to the controller. Every other pair is left released.

Which byte holds the port field depends on layout. A strap input, captured while reset is asserted, picks between two layouts. In the default layout the field is bits 2:1 of byte 0x2C. If bit 0 of byte 0x2F is set, the field is bits 2:1 of byte 0x2E instead. In the alternate layout the field is bits 4:3 of byte 0x02. Byte 0x2C also carries the controller enable (bit 0), and bytes 0x2D:0x2C carry the controller base address in bits 15:5. Software is expected to change only the port field, run its transaction, and then write back the original byte.

A change of port never cuts into a transaction. The routing state machine has three states:
- ST_STEADY: the routing matches the field.
- ST_PENDING: the field differs while the controller is busy.
- ST_SWITCH: one cycle with every pair released.

Its transitions are:
- STEADY to SWITCH when the field differs and busy is low.
- STEADY to PENDING when the field differs and busy is high.
- PENDING to SWITCH when busy falls.
- PENDING to STEADY when the field returns to the active port.
- SWITCH to STEADY, which loads the new port.

Top module: `smbus_port_mux`

## Requirements
- R1: A write with io_addr_i=0 loads the index. A read with io_addr_i=0 returns the index. A write or read with io_addr_i=1 accesses the byte the index selects. Read data appears on io_rdata_o on the clock edge that samples io_rd_i.
- R2: Only indices 0x02, 0x2C, 0x2D, 0x2E and 0x2F are implemented. Any other index reads as 0x00, and a write to it changes nothing.
- R3: With the default layout and bit 0 of 0x2F clear, bits 2:1 of 0x2C give the active port number.
- R4: With the default layout and bit 0 of 0x2F set, bits 2:1 of 0x2E give the port, and the field in 0x2C has no effect.
- R5: With layout_alt_i high during reset, bits 4:3 of 0x02 give the port, and the fields in 0x2C and 0x2E have no effect.
- R6: For the active port p, port_scl_oe_o[p] follows host_scl_oe_i and port_sda_oe_o[p] follows host_sda_oe_i, while host_scl_o and host_sda_o follow port_scl_i[p] and port_sda_i[p]. Every other port's enables are 0, and its inputs have no effect.
- R7: While ctrl_busy_i is high outside a switch, active_port_o does not change. A pending change starts on the first cycle with busy low.
- R8: A port change takes two cycles. In the first, all enables are 0 and host_scl_o and host_sda_o read 1. In the second, active_port_o takes the new port.
- R9: ctrl_enable_o equals bit 0 of 0x2C. ctrl_base_o equals {0x2D, 0x2C[7:5], 5'b0}.
- R10: After reset, the index is 0, byte 0x2C is 0x01, the other bytes are 0x00, and port 0 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| layout_alt_i | input | 1 | Layout strap, captured during reset |
| io_addr_i | input | 1 | 0 selects index, 1 selects data |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Registered read data |
| ctrl_busy_i | input | 1 | Controller transaction in progress |
| ctrl_enable_o | output | 1 | Controller enable bit |
| ctrl_base_o | output | 16 | Controller base address |
| host_scl_oe_i | input | 1 | Controller clock pull-down enable |
| host_sda_oe_i | input | 1 | Controller data pull-down enable |
| host_scl_o | output | 1 | Clock level returned to controller |
| host_sda_o | output | 1 | Data level returned to controller |
| port_scl_oe_o | output | 4 | Per-port clock pull-down enables |
| port_sda_oe_o | output | 4 | Per-port data pull-down enables |
| port_scl_i | input | 4 | Per-port clock levels |
| port_sda_i | input | 4 | Per-port data levels |
| active_port_o | output | 2 | Port currently routed |

## Verification
The hardest case to reach is a field change that waits in ST_PENDING. It needs busy raised before the index and data writes, and then held for several cycles before it falls. The stimulus raises ctrl_busy_i first, rewrites the select byte, and checks that the old routing holds on every cycle. It then drops busy and checks for the released cycle followed by the new port. The layout selection is also checked: the source byte is switched through 0x2F, and the block is reset a second time with the strap high.

// File: rtl/smbmux_pkg.sv
package smbmux_pkg;
    localparam int REG_W = 8;

    // Implemented indices; positions are decoded by the routing logic
    localparam logic [REG_W-1:0] IDX_ALT_SEL = 8'h02;
    localparam logic [REG_W-1:0] IDX_CFG_LO  = 8'h2C;
    localparam logic [REG_W-1:0] IDX_CFG_HI  = 8'h2D;
    localparam logic [REG_W-1:0] IDX_SEL_B   = 8'h2E;
    localparam logic [REG_W-1:0] IDX_SRC_CTL = 8'h2F;

    localparam logic [REG_W-1:0] RST_CFG_LO  = 8'h01;

    // Least significant bit of the port field in each layout
    localparam int DEF_LSB = 1;
    localparam int ALT_LSB = 3;

    typedef enum logic [1:0] {
        ST_STEADY  = 2'd0,
        ST_PENDING = 2'd1,
        ST_SWITCH  = 2'd2
    } route_st_e;

    typedef struct packed {
        logic [REG_W-1:0] alt_sel;
        logic [REG_W-1:0] cfg_lo;
        logic [REG_W-1:0] cfg_hi;
        logic [REG_W-1:0] sel_b;
        logic [REG_W-1:0] src_ctl;
    } pm_regs_t;

    function automatic logic is_impl(input logic [REG_W-1:0] idx);
        return (idx == IDX_ALT_SEL) || (idx == IDX_CFG_LO) || (idx == IDX_CFG_HI)
            || (idx == IDX_SEL_B) || (idx == IDX_SRC_CTL);
    endfunction
endpackage

// File: rtl/pm_regfile.sv
module pm_regfile
    import smbmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_addr_i,
    input  logic             io_wr_i,
    input  logic             io_rd_i,
    input  logic [REG_W-1:0] io_wdata_i,
    output logic [REG_W-1:0] io_rdata_o,
    output logic [REG_W-1:0] idx_o,
    output pm_regs_t         regs_o
);
    logic [REG_W-1:0] idx_q;
    pm_regs_t         regs_q;
    logic [REG_W-1:0] rdata_q;
    logic [REG_W-1:0] sel_val;

    // Byte addressed by the index; holes read as zero (R2)
    always_comb begin
        unique case (idx_q)
            IDX_ALT_SEL: sel_val = regs_q.alt_sel;
            IDX_CFG_LO:  sel_val = regs_q.cfg_lo;
            IDX_CFG_HI:  sel_val = regs_q.cfg_hi;
            IDX_SEL_B:   sel_val = regs_q.sel_b;
            IDX_SRC_CTL: sel_val = regs_q.src_ctl;
            default:     sel_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q          <= '0;
            regs_q         <= '0;
            regs_q.cfg_lo  <= RST_CFG_LO;
        end else if (io_wr_i) begin
            if (!io_addr_i) begin
                idx_q <= io_wdata_i;
            end else begin
                unique case (idx_q)
                    IDX_ALT_SEL: regs_q.alt_sel <= io_wdata_i;
                    IDX_CFG_LO:  regs_q.cfg_lo  <= io_wdata_i;
                    IDX_CFG_HI:  regs_q.cfg_hi  <= io_wdata_i;
                    IDX_SEL_B:   regs_q.sel_b   <= io_wdata_i;
                    IDX_SRC_CTL: regs_q.src_ctl <= io_wdata_i;
                    default:     ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (io_rd_i)
            rdata_q <= io_addr_i ? sel_val : idx_q;
    end

    assign io_rdata_o = rdata_q;
    assign idx_o      = idx_q;
    assign regs_o     = regs_q;
endmodule

// File: rtl/port_field_dec.sv
module port_field_dec
    import smbmux_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int SEL_W = $clog2(NUM_PORTS)
) (
    input  logic             layout_alt_i,
    input  logic [REG_W-1:0] alt_sel_i,
    input  logic [REG_W-1:0] cfg_lo_i,
    input  logic [REG_W-1:0] sel_b_i,
    input  logic [REG_W-1:0] src_ctl_i,
    output logic [SEL_W-1:0] req_port_o
);
    logic [REG_W-1:0] def_src;
    logic             unused_bits;

    // Bit 0 of the source-control byte picks the default-layout source
    assign def_src = src_ctl_i[0] ? sel_b_i : cfg_lo_i;

    generate
        if (NUM_PORTS > 1) begin : g_field
            assign req_port_o = layout_alt_i ? alt_sel_i[ALT_LSB +: SEL_W]
                                             : def_src[DEF_LSB +: SEL_W];
        end else begin : g_single
            assign req_port_o = '0;
        end
    endgenerate

    assign unused_bits = ^{alt_sel_i, def_src, src_ctl_i[REG_W-1:1]};
endmodule

// File: rtl/route_fsm.sv
module route_fsm
    import smbmux_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int SEL_W = $clog2(NUM_PORTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] req_port_i,
    input  logic             busy_i,
    output logic [SEL_W-1:0] active_port_o,
    output logic             release_o,
    output route_st_e        state_o
);
    route_st_e        state_q, state_d;
    logic [SEL_W-1:0] active_q;
    logic [SEL_W-1:0] target_q;
    logic             differ;

    assign differ = (req_port_i != active_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STEADY:  if (differ) state_d = busy_i ? ST_PENDING : ST_SWITCH;
            ST_PENDING: if (!differ) state_d = ST_STEADY;
                        else if (!busy_i) state_d = ST_SWITCH;
            ST_SWITCH:  state_d = ST_STEADY;
            default:    state_d = ST_STEADY;
        endcase
    end

    // State register, captured target and active port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_STEADY;
            active_q <= '0;
            target_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_SWITCH && state_d == ST_SWITCH)
                target_q <= req_port_i;
            if (state_q == ST_SWITCH)
                active_q <= target_q;
        end
    end

    // Outputs
    always_comb begin
        release_o     = (state_q == ST_SWITCH);
        active_port_o = active_q;
        state_o       = state_q;
    end
endmodule

// File: rtl/pair_router.sv
module pair_router #(
    parameter int NUM_PORTS = 4,
    localparam int SEL_W = $clog2(NUM_PORTS)
) (
    input  logic [SEL_W-1:0]     active_i,
    input  logic                 release_i,
    input  logic                 host_scl_oe_i,
    input  logic                 host_sda_oe_i,
    output logic                 host_scl_o,
    output logic                 host_sda_o,
    output logic [NUM_PORTS-1:0] port_scl_oe_o,
    output logic [NUM_PORTS-1:0] port_sda_oe_o,
    input  logic [NUM_PORTS-1:0] port_scl_i,
    input  logic [NUM_PORTS-1:0] port_sda_i
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM_PORTS; gi++) begin : g_pair
            logic hit;
            assign hit               = !release_i && (active_i == SEL_W'(gi));
            assign port_scl_oe_o[gi] = hit && host_scl_oe_i;
            assign port_sda_oe_o[gi] = hit && host_sda_oe_i;
        end
    endgenerate

    // Released bus reads as pulled up
    assign host_scl_o = release_i ? 1'b1 : port_scl_i[active_i];
    assign host_sda_o = release_i ? 1'b1 : port_sda_i[active_i];
endmodule

// File: rtl/smbus_port_mux.sv
module smbus_port_mux
    import smbmux_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int SEL_W = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 layout_alt_i,
    input  logic                 io_addr_i,
    input  logic                 io_wr_i,
    input  logic                 io_rd_i,
    input  logic [7:0]           io_wdata_i,
    output logic [7:0]           io_rdata_o,
    input  logic                 ctrl_busy_i,
    output logic                 ctrl_enable_o,
    output logic [15:0]          ctrl_base_o,
    input  logic                 host_scl_oe_i,
    input  logic                 host_sda_oe_i,
    output logic                 host_scl_o,
    output logic                 host_sda_o,
    output logic [NUM_PORTS-1:0] port_scl_oe_o,
    output logic [NUM_PORTS-1:0] port_sda_oe_o,
    input  logic [NUM_PORTS-1:0] port_scl_i,
    input  logic [NUM_PORTS-1:0] port_sda_i,
    output logic [SEL_W-1:0]     active_port_o
);
    logic             layout_q;
    pm_regs_t         regs;
    logic [REG_W-1:0] idx_w;
    logic [SEL_W-1:0] req_port;
    logic [SEL_W-1:0] active_w;
    logic             release_w;
    route_st_e        route_st;

    // Strap captured while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n)
            layout_q <= layout_alt_i;
    end

    pm_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr_i  (io_addr_i),
        .io_wr_i    (io_wr_i),
        .io_rd_i    (io_rd_i),
        .io_wdata_i (io_wdata_i),
        .io_rdata_o (io_rdata_o),
        .idx_o      (idx_w),
        .regs_o     (regs)
    );

    port_field_dec #(.NUM_PORTS(NUM_PORTS)) u_dec (
        .layout_alt_i (layout_q),
        .alt_sel_i    (regs.alt_sel),
        .cfg_lo_i     (regs.cfg_lo),
        .sel_b_i      (regs.sel_b),
        .src_ctl_i    (regs.src_ctl),
        .req_port_o   (req_port)
    );

    route_fsm #(.NUM_PORTS(NUM_PORTS)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_port_i    (req_port),
        .busy_i        (ctrl_busy_i),
        .active_port_o (active_w),
        .release_o     (release_w),
        .state_o       (route_st)
    );

    pair_router #(.NUM_PORTS(NUM_PORTS)) u_route (
        .active_i      (active_w),
        .release_i     (release_w),
        .host_scl_oe_i (host_scl_oe_i),
        .host_sda_oe_i (host_sda_oe_i),
        .host_scl_o    (host_scl_o),
        .host_sda_o    (host_sda_o),
        .port_scl_oe_o (port_scl_oe_o),
        .port_sda_oe_o (port_sda_oe_o),
        .port_scl_i    (port_scl_i),
        .port_sda_i    (port_sda_i)
    );

    assign active_port_o = active_w;
    assign ctrl_enable_o = regs.cfg_lo[0];
    assign ctrl_base_o   = {regs.cfg_hi, regs.cfg_lo[7:5], 5'b0};
endmodule

// File: rtl/smbmux_chk.sv
module smbmux_chk
    import smbmux_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int SEL_W = $clog2(NUM_PORTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctrl_busy_i,
    input route_st_e            route_st,
    input logic [SEL_W-1:0]     active_port_o,
    input logic [NUM_PORTS-1:0] port_scl_oe_o,
    input logic [NUM_PORTS-1:0] port_sda_oe_o,
    input logic                 io_rd_i,
    input logic                 io_addr_i,
    input logic [REG_W-1:0]     idx_w,
    input logic [REG_W-1:0]     io_rdata_o
);
    logic [NUM_PORTS-1:0] sel_mask;
    assign sel_mask = NUM_PORTS'(1) << active_port_o;

    // R6
    single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_scl_oe_o) && $onehot0(port_sda_oe_o));

    // R6
    unselected_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_scl_oe_o | port_sda_oe_o) & ~sel_mask) == '0);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_busy_i && route_st != ST_SWITCH) |=> $stable(active_port_o));

    // R8
    break_before_make_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_port_o) |-> ($past(port_scl_oe_o) == '0 && $past(port_sda_oe_o) == '0));

    // R2
    hole_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd_i && io_addr_i && !is_impl(idx_w)) |=> (io_rdata_o == '0));
endmodule

bind smbus_port_mux smbmux_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_busy_i   (ctrl_busy_i),
    .route_st      (route_st),
    .active_port_o (active_port_o),
    .port_scl_oe_o (port_scl_oe_o),
    .port_sda_oe_o (port_sda_oe_o),
    .io_rd_i       (io_rd_i),
    .io_addr_i     (io_addr_i),
    .idx_w         (idx_w),
    .io_rdata_o    (io_rdata_o)
);

// File: tb/smbus_port_mux_bench.sv
module smbus_port_mux_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       layout_alt = 0;
    logic       io_addr = 0, io_wr = 0, io_rd = 0;
    logic [7:0] io_wdata = 0;
    logic [7:0] io_rdata;
    logic       busy = 0;
    logic       ctrl_en;
    logic [15:0] ctrl_base;
    logic       h_scl_oe = 1, h_sda_oe = 1;
    logic       h_scl, h_sda;
    logic [3:0] p_scl_oe, p_sda_oe;
    logic [3:0] p_scl = 4'b1010, p_sda = 4'b0110;
    logic [1:0] active;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_port_mux u_smbus_port_mux (
        .clk(clk), .rst_n(rst_n), .layout_alt_i(layout_alt),
        .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
        .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
        .ctrl_busy_i(busy), .ctrl_enable_o(ctrl_en), .ctrl_base_o(ctrl_base),
        .host_scl_oe_i(h_scl_oe), .host_sda_oe_i(h_sda_oe),
        .host_scl_o(h_scl), .host_sda_o(h_sda),
        .port_scl_oe_o(p_scl_oe), .port_sda_oe_o(p_sda_oe),
        .port_scl_i(p_scl), .port_sda_i(p_sda), .active_port_o(active)
    );

    typedef struct {
        int          kind;   // 0 read data, 1 routing, 2 controller fields
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // Scoreboard monitor: compares at the falling edge after each push
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = {24'b0, io_rdata};
                1:       act = {20'b0, p_scl_oe, p_sda_oe, h_scl, h_sda, active};
                default: act = {15'b0, ctrl_en, ctrl_base};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind %0d actual %h expected %h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    function automatic logic [31:0] route_vec(input int p, input bit rel, input int act_p);
        logic [3:0] m;
        m = rel ? 4'b0 : (4'b1 << p);
        return {20'b0, h_scl_oe ? m : 4'b0, h_sda_oe ? m : 4'b0,
                rel ? 1'b1 : p_scl[p], rel ? 1'b1 : p_sda[p], 2'(act_p)};
    endfunction

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic io_write(input logic a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1;
        tick();
        io_wr = 0;
    endtask

    task automatic io_read(input logic a, input logic [7:0] exp, input string tag);
        io_addr = a; io_rd = 1;
        push(0, {24'b0, exp}, tag);
        tick();
        io_rd = 0;
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
        io_write(0, idx);
        io_write(1, val);
    endtask

    // Routing expectation for the coming falling edge; rel marks the released cycle
    task automatic expect_route(input int p, input bit rel, input int act_p, input string tag);
        push(1, route_vec(p, rel, act_p), tag);
        tick();
    endtask

    task automatic expect_ctrl(input bit en, input logic [15:0] base, input string tag);
        push(2, {15'b0, en, base}, tag);
        tick();
    endtask

    task automatic do_reset(input bit strap);
        rst_n = 0; layout_alt = strap;
        repeat (3) tick();
        rst_n = 1;
        tick();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        do_reset(0);
        // R10 reset state
        expect_route(0, 0, 0, "R10");
        expect_ctrl(1, 16'h0000, "R10");
        io_read(0, 8'h00, "R10");

        // R1 index and data access
        io_write(0, 8'h2E);
        io_read(0, 8'h2E, "R1");
        io_write(1, 8'h5A);
        io_read(1, 8'h5A, "R1");

        // R2 unimplemented index
        set_reg(8'h55, 8'hAA);
        io_read(1, 8'h00, "R2");
        io_write(0, 8'h2D);
        io_read(1, 8'h00, "R2");
        expect_route(0, 0, 0, "R2");

        // R3 default source; R8 released cycle then new port
        set_reg(8'h2C, 8'h05);
        expect_route(0, 1, 0, "R8");
        expect_route(2, 0, 2, "R3");

        // R9 controller fields, same field so no switch
        set_reg(8'h2D, 8'h12);
        set_reg(8'h2C, 8'hE5);
        expect_ctrl(1, 16'h12E0, "R9");
        expect_route(2, 0, 2, "R3");

        // R4 alternate source selected by 0x2F bit 0
        set_reg(8'h2E, 8'h06);
        expect_route(2, 0, 2, "R4");
        expect_route(2, 0, 2, "R4");
        set_reg(8'h2F, 8'h01);
        expect_route(2, 1, 2, "R4");
        expect_route(3, 0, 3, "R4");
        set_reg(8'h2C, 8'hE1);
        expect_route(3, 0, 3, "R4");
        expect_route(3, 0, 3, "R4");

        // R7 change held while busy
        busy = 1;
        set_reg(8'h2E, 8'h02);
        for (int i = 0; i < 4; i++) expect_route(3, 0, 3, "R7");
        busy = 0;
        expect_route(3, 1, 3, "R7");
        expect_route(1, 0, 1, "R7");

        // R6 unselected inputs ignored, enables follow host
        p_scl = p_scl ^ 4'b1101;
        p_sda = p_sda ^ 4'b1101;
        expect_route(1, 0, 1, "R6");
        h_sda_oe = 0;
        expect_route(1, 0, 1, "R6");
        h_scl_oe = 0; h_sda_oe = 1;
        expect_route(1, 0, 1, "R6");
        h_scl_oe = 1;

        // R3 restore original source, field of 0x2C is 0
        set_reg(8'h2F, 8'h00);
        expect_route(1, 1, 1, "R8");
        expect_route(0, 0, 0, "R3");

        // R5 alternate layout strap
        do_reset(1);
        expect_route(0, 0, 0, "R10");
        set_reg(8'h2C, 8'h07);
        expect_route(0, 0, 0, "R5");
        expect_route(0, 0, 0, "R5");
        set_reg(8'h02, 8'h10);
        expect_route(0, 1, 0, "R5");
        expect_route(2, 0, 2, "R5");

        tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule